// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns one memory-protection entry into the inclusive byte range that it covers. It takes the entry's 2-bit address-match mode, the entry's own address word, and the address word of the entry just below it. It returns a start byte address, an end byte address and a flag that says whether any address can match at all. An address word holds a byte address divided by four, so every output is two bits wider than the address words. This keeps the largest power-of-two region and the top of a top-of-range region from wrapping.

The result is registered. Inputs sampled on one rising edge appear at the outputs after that edge and stay there until the next edge. A protection checker uses the block once per entry. It feeds each entry's word to its upper neighbour as the previous word, and entry 0 gets zero. It then compares access addresses against the registered bounds. The block checks no permissions.

Top module: `rb_region_bounds`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `region_live_o`=0, `region_lo_o`=0 and `region_hi_o`=0, whatever the inputs are.
- R2: The outputs after a rising edge depend only on the inputs sampled at that edge (one cycle of latency), and they hold until the next edge.
- R3: Mode code 0 (off) gives `region_live_o`=0 and both bounds 0. The address words have no effect.
- R4: Mode code 1 (top-of-range) with `prev_addr_i` < `cur_addr_i` gives live=1, start=`prev_addr_i`*4 and end=`cur_addr_i`*4-1, computed without wrap in XLEN+2 bits.
- R5: Mode code 1 with `prev_addr_i` >= `cur_addr_i` (equal, inverted, or both zero) gives an empty region: live=0 and both bounds 0.
- R6: Mode code 2 (four-byte) gives live=1, start=`cur_addr_i`*4 and end=start+3.
- R7: Mode code 3 (power-of-two) with k trailing one bits in `cur_addr_i` (k < XLEN) gives live=1 and a region of 2^(k+3) bytes. Its start is `cur_addr_i`*4 with the low k+3 bits cleared, and its end is start+2^(k+3)-1. For example, low bit 0 gives 8 bytes and low bits 01 give 16 bytes.
- R8: Mode code 3 with `cur_addr_i` all ones, or with k = XLEN-1, gives the whole space: start 0 and end 2^(XLEN+2)-1.
- R9: Whenever `region_live_o` is 1, start <= end. Whenever it is 0, both bounds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Match mode: 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two |
| cur_addr_i | input | XLEN | This entry's address word (byte address / 4) |
| prev_addr_i | input | XLEN | Lower neighbour's address word, 0 for entry 0 |
| region_lo_o | output | XLEN+2 | Inclusive start byte address |
| region_hi_o | output | XLEN+2 | Inclusive end byte address |
| region_live_o | output | 1 | 1 when at least one address matches |

## Verification
The only state is the output register. A fault in it, or in the path that feeds it, shows up at the ports one edge after the inputs that expose it. Each cycle is compared against an independent range model, so a wrong bound appears within a single cycle. Such a fault might be a wrapped subtraction, a mis-sized power-of-two mask, or an inverted top-of-range test. The stimulus includes inputs that change on every edge, which would expose a stale or doubly delayed register. It also covers the equal and zero top-of-range cases and the two whole-space power-of-two words, where arithmetic that is too narrow would fail.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/rb_tor_span.sv
module rb_tor_span #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned AW  = XLEN + rb_pkg::WORD_SHIFT
) (
    input  logic [XLEN-1:0] prev_w,
    input  logic [XLEN-1:0] cur_w,
    output logic [AW-1:0]   lo,
    output logic [AW-1:0]   hi,
    output logic            live
);
    logic [AW-1:0] top_byte;

    always_comb begin
        live     = (cur_w > prev_w);
        top_byte = {cur_w, 2'b00};
        lo       = '0;
        hi       = '0;
        if (live) begin
            lo = {prev_w, 2'b00};
            hi = top_byte - AW'(1);
        end
    end
endmodule

// File: rtl/rb_na4_span.sv
module rb_na4_span #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned AW  = XLEN + rb_pkg::WORD_SHIFT
) (
    input  logic [XLEN-1:0] cur_w,
    output logic [AW-1:0]   lo,
    output logic [AW-1:0]   hi
);
    assign lo = {cur_w, 2'b00};
    assign hi = {cur_w, 2'b11};
endmodule

// File: rtl/rb_pow2_span.sv
module rb_pow2_span #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned AW  = XLEN + rb_pkg::WORD_SHIFT
) (
    input  logic [XLEN-1:0] cur_w,
    output logic [AW-1:0]   lo,
    output logic [AW-1:0]   hi
);
    logic [AW-1:0] ones_ext;
    logic [AW-1:0] carry_up;

    always_comb begin
        ones_ext = {cur_w, 2'b11};
        carry_up = ones_ext + AW'(1);
        lo       = ones_ext & carry_up;
        hi       = ones_ext | carry_up;
    end
endmodule

// File: rtl/rb_region_bounds.sv
module rb_region_bounds
    import rb_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    localparam int unsigned AW  = XLEN + WORD_SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] cur_addr_i,
    input  logic [XLEN-1:0] prev_addr_i,
    output logic [AW-1:0]   region_lo_o,
    output logic [AW-1:0]   region_hi_o,
    output logic            region_live_o
);
    typedef struct packed {
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
        logic          live;
    } span_t;

    span_t tor_s, na4_s, pow_s, pick_s, held_q;
    logic  tor_live;

    rb_tor_span #(.XLEN(XLEN)) u_tor (
        .prev_w (prev_addr_i),
        .cur_w  (cur_addr_i),
        .lo     (tor_s.lo),
        .hi     (tor_s.hi),
        .live   (tor_live)
    );

    rb_na4_span #(.XLEN(XLEN)) u_na4 (
        .cur_w (cur_addr_i),
        .lo    (na4_s.lo),
        .hi    (na4_s.hi)
    );

    rb_pow2_span #(.XLEN(XLEN)) u_pow (
        .cur_w (cur_addr_i),
        .lo    (pow_s.lo),
        .hi    (pow_s.hi)
    );

    assign tor_s.live = tor_live;
    assign na4_s.live = 1'b1;
    assign pow_s.live = 1'b1;

    always_comb begin
        unique case (match_mode_e'(mode_i))
            MATCH_TOR:   pick_s = tor_s;
            MATCH_NA4:   pick_s = na4_s;
            MATCH_NAPOT: pick_s = pow_s;
            default:     pick_s = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            held_q <= pick_s;
        end
    end

    assign region_lo_o   = held_q.lo;
    assign region_hi_o   = held_q.hi;
    assign region_live_o = held_q.live;
endmodule

// File: rtl/rb_region_bounds_chk.sv
module rb_region_bounds_chk #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned AW  = XLEN + 2
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode_i,
    input logic [XLEN-1:0] cur_addr_i,
    input logic [XLEN-1:0] prev_addr_i,
    input logic [AW-1:0]   region_lo_o,
    input logic [AW-1:0]   region_hi_o,
    input logic            region_live_o
);
    logic [AW-1:0] span_w;
    assign span_w = region_hi_o - region_lo_o;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!region_live_o && region_lo_o == '0 && region_hi_o == '0));

    // R3
    a_r3_off_empty: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0) |=> !region_live_o);

    // R4
    a_r4_tor_top: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && prev_addr_i < cur_addr_i)
        |=> (region_live_o && region_hi_o + AW'(1) == {$past(cur_addr_i), 2'b00}));

    // R5
    a_r5_tor_inverted: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && prev_addr_i >= cur_addr_i) |=> !region_live_o);

    // R6
    a_r6_na4_width: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2) |=> (region_live_o && span_w == AW'(3)));

    // R7
    a_r7_pow2_aligned: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd3)
        |=> (region_live_o && ((span_w + AW'(1)) & span_w) == '0
             && (region_lo_o & span_w) == '0));

    // R9
    a_r9_ordered: assert property (@(posedge clk) disable iff (rst)
        region_live_o |-> (region_lo_o <= region_hi_o));

    // R9
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
        !region_live_o |-> (region_lo_o == '0 && region_hi_o == '0));
endmodule

bind rb_region_bounds rb_region_bounds_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_rb_region_bounds.sv
`timescale 1ns/1ps
module sim_rb_region_bounds;
    localparam int XLEN = 32;
    localparam int AW   = XLEN + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode_i = 2'd0;
    logic [XLEN-1:0] cur_addr_i = '0;
    logic [XLEN-1:0] prev_addr_i = '0;
    logic [AW-1:0]   region_lo_o;
    logic [AW-1:0]   region_hi_o;
    logic            region_live_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    typedef struct {
        longint unsigned lo;
        longint unsigned hi;
        bit              live;
        string           req;
    } exp_t;

    exp_t pending[$];

    always #4 clk = ~clk;

    rb_region_bounds #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .cur_addr_i(cur_addr_i), .prev_addr_i(prev_addr_i),
        .region_lo_o(region_lo_o), .region_hi_o(region_hi_o),
        .region_live_o(region_live_o)
    );

    function automatic exp_t model(input int m, input longint unsigned cur,
                                   input longint unsigned prev);
        exp_t e;
        longint unsigned full = (64'd1 << AW) - 1;
        int k;
        longint unsigned size;
        e.lo = 0; e.hi = 0; e.live = 0;
        case (m)
            1: begin
                e.req = (prev < cur) ? "R4" : "R5";
                if (prev < cur) begin
                    e.live = 1; e.lo = prev * 4; e.hi = cur * 4 - 1;
                end
            end
            2: begin
                e.req = "R6"; e.live = 1; e.lo = cur * 4; e.hi = cur * 4 + 3;
            end
            3: begin
                k = 0;
                while (k < XLEN && ((cur >> k) & 1) == 1) k++;
                e.req = (k >= XLEN - 1) ? "R8" : "R7";
                size  = 64'd1 << (k + 3);
                e.live = 1;
                e.lo   = (cur * 4) & ~(size - 1) & full;
                e.hi   = (e.lo + size - 1) & full;
            end
            default: e.req = "R3";
        endcase
        return e;
    endfunction

    task automatic compare_one(input exp_t e);
        checks++;
        if (region_lo_o !== AW'(e.lo) || region_hi_o !== AW'(e.hi)
            || region_live_o !== e.live) begin
            errors++;
            $display("FAIL %s (R2 timing): got lo=%h hi=%h live=%b, expected lo=%h hi=%h live=%b",
                     e.req, region_lo_o, region_hi_o, region_live_o,
                     AW'(e.lo), AW'(e.hi), e.live);
        end
    endtask

    task automatic step(input int m, input logic [XLEN-1:0] cur,
                        input logic [XLEN-1:0] prev);
        @(negedge clk);
        if (pending.size() > 0) compare_one(pending.pop_front());
        mode_i      = m[1:0];
        cur_addr_i  = cur;
        prev_addr_i = prev;
        pending.push_back(model(m, longint'(cur), longint'(prev)));
    endtask

    initial begin
        exp_t z;
        z.lo = 0; z.hi = 0; z.live = 0; z.req = "R1";
        mode_i = 2'd2; cur_addr_i = 32'h1234_5678; prev_addr_i = 32'h10;
        repeat (3) @(negedge clk);
        compare_one(z);
        rst = 1'b0;

        step(0, 32'hDEAD_BEEF, 32'h1);
        step(1, 32'h20, 32'h10);
        step(1, 32'hFFFF_FFFF, 32'h0);
        step(1, 32'h5, 32'h5);
        step(1, 32'h3, 32'h9);
        step(1, 32'h0, 32'h0);
        step(2, 32'h1234, 32'h0);
        step(2, 32'hFFFF_FFFF, 32'h7);
        step(3, 32'h100, 32'h0);
        step(3, 32'h101, 32'h0);
        step(3, 32'h103, 32'h0);
        step(3, 32'h0007_FFFF, 32'h0);
        step(3, 32'h7FFF_FFFF, 32'h0);
        step(3, 32'hFFFF_FFFF, 32'h0);
        step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(2, 32'h0, 32'h0);

        for (int i = 0; i < 600; i++) begin
            logic [XLEN-1:0] c;
            logic [XLEN-1:0] p;
            int tz;
            c  = $urandom;
            p  = $urandom;
            tz = $urandom_range(0, XLEN);
            for (int b = 0; b < tz; b++) c[b] = 1'b1;
            if (i % 5 == 0) p = c - XLEN'($urandom_range(0, 3));
            step($urandom_range(0, 3), c, p);
        end

        @(negedge clk);
        while (pending.size() > 0) compare_one(pending.pop_front());

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected finish before timeout");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule